// File: doc/BRIEF.md
# Network DMA Interrupt Status and Summary

This block collects the interrupt events of a network DMA engine and its MAC into one status register. Each event is a single-cycle pulse. It sets its own sticky bit, and that bit stays set until software writes a 1 to its position. The event bits fall into two groups, normal and abnormal. Each group feeds a registered summary bit. The summary bit is high when any member of the group is set and enabled in the matching enable register.

A single level-sensitive interrupt line is driven from the two summary bits. Each summary bit is gated by its own enable at the summary position. The line is not a pulse train. Events that arrive together, or that arrive while the line is already high, produce no extra edge. The line only falls once every enabled pending bit has been cleared. It only rises again when a new event arrives or when an enable is set.

A bus error reported by the DMA does three things: it sets a fatal status bit, it latches an error-type code, and it raises a halt request. The halt request stays up until software clears the fatal bit. Software reaches both registers through a one-cycle register port with valid, write, address and data signals.

Top module: `netdma_irq_ctrl`

## Requirements
- R1: After reset the status word, the enable word and the read data are all zero, and `irq` and `halt_req` are low.
- R2: An event pulse sets its sticky status bit at the next clock edge. The bit positions are: transmit done 0, transmit stopped 1, transmit no-buffer 2, receive done 6, receive no-buffer 7, receive stopped 8, fatal bus error 13, early receive 14.
- R3: Writing to address 0 clears each member bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged. When an event sets a bit in the same cycle that a write clears it, the bit stays set.
- R4: Status bit 16 is the normal summary, covering bits 0, 2, 6 and 14. Status bit 15 is the abnormal summary, covering bits 1, 7, 8 and 13. Each summary is the registered OR of the members that are both set and enabled, so it follows them one clock later. Writing to positions 15 and 16 of the status word has no effect.
- R5: `irq` is high when the normal summary is high and enable bit 16 is set, or when the abnormal summary is high and enable bit 15 is set. A pending status bit whose enable bit is 0 does not raise `irq`.
- R6: Clearing one status bit does not lower `irq` while another enabled member is still set.
- R7: Several events that arrive together give a single assertion of `irq`. Once every enabled bit is cleared, `irq` is low and stays low until a new event arrives.
- R8: A `bus_err` pulse sets bit 13 and raises `halt_req`, which holds until bit 13 is cleared. The error type is latched into status bits 25:23 when bit 13 was not already set. A later error does not overwrite the type while bit 13 stays set. Clearing bit 13 zeroes the type.
- R9: A read request presents its data on `reg_rdata` after the next clock edge. Address 0 returns the status word. Address 1 returns the enable word, whose writable bits are 0, 1, 2, 6, 7, 8, 13, 14, 15 and 16, so writing all ones reads back 0x1E1C7. Every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_tx_done | input | 1 | Pulse: transmit frame done |
| evt_tx_stopped | input | 1 | Pulse: transmit engine stopped |
| evt_tx_nobuf | input | 1 | Pulse: transmit buffer unavailable |
| evt_rx_done | input | 1 | Pulse: received frame written to host memory |
| evt_rx_nobuf | input | 1 | Pulse: no receive buffer available |
| evt_rx_stopped | input | 1 | Pulse: receive engine stopped |
| evt_rx_early | input | 1 | Pulse: early receive |
| bus_err | input | 1 | Pulse: bus slave returned an error response |
| bus_err_type | input | ERR_W | Error type accompanying `bus_err` |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Word address (0 status, 1 enable) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after a read |
| irq | output | 1 | Level interrupt |
| halt_req | output | 1 | Request to the DMA to stop all operations |

## Verification
Directed cases cover single events, two coinciding events, a clear of one bit while a second enabled bit is pending, and an event that lands on a clear of the same bit. Together they separate the behaviour a level-held, non-queued line must have from the behaviour of a pulse or a per-event output. A pending bit with its enable at 0, and writes to the summary positions, show that only enabled members reach the summary bits and that software cannot force them. Repeated bus errors with different types confirm that the first type is kept and that halt is held. A long random run with sparse events, random write-1 clears, random enable writes and reads of every address then compares `irq`, `halt_req` and each read result against a cycle model in the bench.

// File: rtl/netdma_irq_pkg.sv
package netdma_irq_pkg;

  localparam int STAT_W = 17;

  // bit positions in the status word (and matching enable word)
  localparam int B_TXDONE  = 0;
  localparam int B_TXSTOP  = 1;
  localparam int B_TXNOBUF = 2;
  localparam int B_RXDONE  = 6;
  localparam int B_RXNOBUF = 7;
  localparam int B_RXSTOP  = 8;
  localparam int B_FATAL   = 13;
  localparam int B_RXEARLY = 14;
  localparam int B_ASUM    = 15;
  localparam int B_NSUM    = 16;
  localparam int ERR_LSB   = 23;

  localparam logic [STAT_W-1:0] NORM_MASK = STAT_W'((1 << B_TXDONE) | (1 << B_TXNOBUF) |
                                                    (1 << B_RXDONE) | (1 << B_RXEARLY));
  localparam logic [STAT_W-1:0] ABN_MASK  = STAT_W'((1 << B_TXSTOP) | (1 << B_RXNOBUF) |
                                                    (1 << B_RXSTOP) | (1 << B_FATAL));
  localparam logic [STAT_W-1:0] MEMB_MASK = NORM_MASK | ABN_MASK;
  localparam logic [STAT_W-1:0] SUM_MASK  = STAT_W'((1 << B_NSUM) | (1 << B_ASUM));
  localparam logic [STAT_W-1:0] EN_MASK   = MEMB_MASK | SUM_MASK;

  typedef struct packed {
    logic tx_done;
    logic tx_stop;
    logic tx_nobuf;
    logic rx_done;
    logic rx_nobuf;
    logic rx_stop;
    logic rx_early;
    logic bus_err;
  } evt_t;

  // place event pulses at their status positions
  function automatic logic [STAT_W-1:0] evt_to_vec(evt_t e);
    logic [STAT_W-1:0] v;
    v = '0;
    v[B_TXDONE]  = e.tx_done;
    v[B_TXSTOP]  = e.tx_stop;
    v[B_TXNOBUF] = e.tx_nobuf;
    v[B_RXDONE]  = e.rx_done;
    v[B_RXNOBUF] = e.rx_nobuf;
    v[B_RXSTOP]  = e.rx_stop;
    v[B_RXEARLY] = e.rx_early;
    v[B_FATAL]   = e.bus_err;
    return v;
  endfunction

  // next value of sticky bits: set has priority over clear
  function automatic logic [STAT_W-1:0] sticky_next(logic [STAT_W-1:0] cur,
                                                    logic [STAT_W-1:0] set,
                                                    logic [STAT_W-1:0] clr);
    return ((cur & ~clr) | set) & MEMB_MASK;
  endfunction

  function automatic logic group_hit(logic [STAT_W-1:0] stat,
                                     logic [STAT_W-1:0] en,
                                     logic [STAT_W-1:0] mask);
    return |(stat & en & mask);
  endfunction

endpackage

// File: rtl/netdma_irq_status.sv
module netdma_irq_status
  import netdma_irq_pkg::*;
#(
  parameter int ERR_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  evt_t                evt,
  input  logic [ERR_W-1:0]    err_type,
  input  logic [STAT_W-1:0]   clr_vec,
  output logic [STAT_W-1:0]   stat_q,
  output logic [ERR_W-1:0]    err_type_q,
  output logic                halt_req
);

  logic [STAT_W-1:0] set_vec;
  logic              type_load;
  logic              type_wipe;

  assign set_vec   = evt_to_vec(evt);
  assign type_load = evt.bus_err && (!stat_q[B_FATAL] || clr_vec[B_FATAL]);
  assign type_wipe = clr_vec[B_FATAL] && !evt.bus_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q     <= '0;
      err_type_q <= '0;
    end else begin
      stat_q <= sticky_next(stat_q, set_vec, clr_vec);
      if (type_load)      err_type_q <= err_type;
      else if (type_wipe) err_type_q <= '0;
    end
  end

  assign halt_req = stat_q[B_FATAL];

  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec))); // R2

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((stat_q & $past(clr_vec & ~set_vec)) == '0)); // R3

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !clr_vec[B_FATAL]) |=> halt_req); // R8

  AST_ERRTYPE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[B_FATAL] && !clr_vec[B_FATAL]) |=> $stable(err_type_q)); // R8

endmodule

// File: rtl/netdma_irq_summary.sv
module netdma_irq_summary
  import netdma_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] stat,
  input  logic [STAT_W-1:0] en,
  output logic              nsum_q,
  output logic              asum_q,
  output logic              irq
);

  localparam int NGRP = 2;

  logic [NGRP-1:0] grp_hit;
  logic [NGRP-1:0] sum_q;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [STAT_W-1:0] GMASK = (g == 0) ? NORM_MASK : ABN_MASK;
    assign grp_hit[g] = group_hit(stat, en, GMASK);
    always_ff @(posedge clk) begin
      if (!rst_n) sum_q[g] <= 1'b0;
      else        sum_q[g] <= grp_hit[g];
    end
  end

  assign nsum_q = sum_q[0];
  assign asum_q = sum_q[1];
  assign irq    = (nsum_q & en[B_NSUM]) | (asum_q & en[B_ASUM]);

  AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!nsum_q && !asum_q) |-> !irq); // R7

  AST_SUM_LAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_hit == '0) |=> (sum_q == '0)); // R4

endmodule

// File: rtl/netdma_irq_regif.sv
module netdma_irq_regif
  import netdma_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int ERR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STAT_W-1:0] stat,
  input  logic              nsum,
  input  logic              asum,
  input  logic [ERR_W-1:0]  err_type,
  output logic [STAT_W-1:0] clr_vec,
  output logic [STAT_W-1:0] en_q,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(1);

  logic              wr_status;
  logic              wr_enable;
  logic              rd_req;
  logic [DATA_W-1:0] status_word;
  logic [DATA_W-1:0] enable_word;
  logic              unused_wdata_hi;

  assign wr_status = valid && write && (addr == A_STATUS);
  assign wr_enable = valid && write && (addr == A_ENABLE);
  assign rd_req    = valid && !write;
  assign clr_vec   = wr_status ? (wdata[STAT_W-1:0] & MEMB_MASK) : '0;
  assign unused_wdata_hi = ^wdata[DATA_W-1:STAT_W];

  always_comb begin
    status_word = '0;
    status_word[STAT_W-1:0]        = stat;
    status_word[B_NSUM]            = nsum;
    status_word[B_ASUM]            = asum;
    status_word[ERR_LSB +: ERR_W]  = err_type;
    enable_word = '0;
    enable_word[STAT_W-1:0]        = en_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      rdata <= '0;
    end else begin
      if (wr_enable) en_q <= wdata[STAT_W-1:0] & EN_MASK;
      if (rd_req) begin
        case (addr)
          A_STATUS: rdata <= status_word;
          A_ENABLE: rdata <= enable_word;
          default:  rdata <= '0;
        endcase
      end
    end
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (addr > A_ENABLE)) |=> (rdata == '0)); // R9

endmodule

// File: rtl/netdma_irq_ctrl.sv
module netdma_irq_ctrl
  import netdma_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int ERR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_tx_done,
  input  logic              evt_tx_stopped,
  input  logic              evt_tx_nobuf,
  input  logic              evt_rx_done,
  input  logic              evt_rx_nobuf,
  input  logic              evt_rx_stopped,
  input  logic              evt_rx_early,
  input  logic              bus_err,
  input  logic [ERR_W-1:0]  bus_err_type,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              halt_req
);

  evt_t              evt;
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] en_q;
  logic [ERR_W-1:0]  err_type_q;
  logic              nsum_q;
  logic              asum_q;
  logic              enabled_pending;

  assign evt = '{tx_done:  evt_tx_done,  tx_stop:  evt_tx_stopped,
                 tx_nobuf: evt_tx_nobuf, rx_done:  evt_rx_done,
                 rx_nobuf: evt_rx_nobuf, rx_stop:  evt_rx_stopped,
                 rx_early: evt_rx_early, bus_err:  bus_err};

  assign enabled_pending = |(stat_q & en_q & MEMB_MASK);

  netdma_irq_status #(.ERR_W(ERR_W)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (evt),
    .err_type   (bus_err_type),
    .clr_vec    (clr_vec),
    .stat_q     (stat_q),
    .err_type_q (err_type_q),
    .halt_req   (halt_req)
  );

  netdma_irq_summary u_summary (
    .clk    (clk),
    .rst_n  (rst_n),
    .stat   (stat_q),
    .en     (en_q),
    .nsum_q (nsum_q),
    .asum_q (asum_q),
    .irq    (irq)
  );

  netdma_irq_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERR_W(ERR_W)) u_regif (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (reg_valid),
    .write    (reg_write),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .stat     (stat_q),
    .nsum     (nsum_q),
    .asum     (asum_q),
    .err_type (err_type_q),
    .clr_vec  (clr_vec),
    .en_q     (en_q),
    .rdata    (reg_rdata)
  );

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(enabled_pending)); // R5

endmodule

// File: tb/netdma_irq_ctrl_tb.sv
module netdma_irq_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        e_txd = 0, e_txs = 0, e_txn = 0, e_rxd = 0, e_rxn = 0, e_rxs = 0, e_rxe = 0;
  logic        e_be = 0;
  logic [2:0]  e_bt = '0;
  logic        reg_valid = 0, reg_write = 0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, halt_req;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  netdma_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .evt_tx_done(e_txd), .evt_tx_stopped(e_txs), .evt_tx_nobuf(e_txn),
    .evt_rx_done(e_rxd), .evt_rx_nobuf(e_rxn), .evt_rx_stopped(e_rxs),
    .evt_rx_early(e_rxe), .bus_err(e_be), .bus_err_type(e_bt),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .halt_req(halt_req)
  );

  // ---------------- bench model, written from the requirements ----------------
  localparam logic [31:0] M_NORM = 32'h0000_4045;
  localparam logic [31:0] M_ABN  = 32'h0000_2182;
  localparam logic [31:0] M_EN   = 32'h0001_E1C7;

  logic [31:0] m_st = '0, m_en = '0, m_rd = '0;
  logic [2:0]  m_et = '0;
  logic        m_ns = 0, m_as = 0, m_rdchk = 0;

  function automatic logic [31:0] ev_bits(logic txd, txs, txn, rxd, rxn, rxs, rxe, be);
    logic [31:0] r = '0;
    if (rxe) r |= 32'h4000;
    if (be)  r |= 32'h2000;
    if (rxs) r |= 32'h0100;
    if (rxn) r |= 32'h0080;
    if (rxd) r |= 32'h0040;
    if (txn) r |= 32'h0004;
    if (txs) r |= 32'h0002;
    if (txd) r |= 32'h0001;
    return r;
  endfunction

  function automatic logic [31:0] status_word(logic [31:0] st, logic ns, as_, logic [2:0] et);
    return st | (32'(ns) << 16) | (32'(as_) << 15) | (32'(et) << 23);
  endfunction

  always @(posedge clk) begin : model
    logic [31:0] sv, clr;
    if (!rst_n) begin
      m_st <= '0; m_en <= '0; m_rd <= '0; m_et <= '0;
      m_ns <= 0; m_as <= 0; m_rdchk <= 0;
    end else begin
      sv  = ev_bits(e_txd, e_txs, e_txn, e_rxd, e_rxn, e_rxs, e_rxe, e_be);
      clr = (reg_valid && reg_write && reg_addr == 4'd0) ? (reg_wdata & (M_NORM | M_ABN)) : '0;
      m_ns <= |(m_st & m_en & M_NORM);
      m_as <= |(m_st & m_en & M_ABN);
      if (e_be && (!m_st[13] || clr[13])) m_et <= e_bt;
      else if (clr[13])                   m_et <= '0;
      m_st <= (m_st & ~clr) | sv;
      if (reg_valid && reg_write && reg_addr == 4'd1) m_en <= reg_wdata & M_EN;
      if (reg_valid && !reg_write)
        m_rd <= (reg_addr == 4'd0) ? status_word(m_st, m_ns, m_as, m_et) :
                (reg_addr == 4'd1) ? m_en : 32'h0;
      m_rdchk <= reg_valid && !reg_write;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // continuous comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5 irq vs model", 32'(irq), 32'((m_ns & m_en[16]) | (m_as & m_en[15])));
      chk("R8 halt vs model", 32'(halt_req), 32'(m_st[13]));
      if (m_rdchk) chk("R9 rdata vs model", reg_rdata, m_rd);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic rd_chk(logic [3:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_valid = 1; reg_write = 0; reg_addr = a;
    @(negedge clk);
    reg_valid = 0;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic pulse(logic [7:0] v, logic [2:0] bt);
    @(negedge clk);
    {e_be, e_rxe, e_rxs, e_rxn, e_rxd, e_txn, e_txs, e_txd} = v;
    e_bt = bt;
    @(negedge clk);
    {e_be, e_rxe, e_rxs, e_rxn, e_rxd, e_txn, e_txs, e_txd} = '0;
  endtask

  // event vector order: be, rxe, rxs, rxn, rxd, txn, txs, txd
  localparam logic [7:0] V_TXD = 8'h01, V_RXD = 8'h08, V_RXN = 8'h10, V_BE = 8'h80;

  initial begin : wdog
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    idle(3);
    rst_n = 1;
    idle(1);
    chk("R1 irq after reset", 32'(irq), 0);
    chk("R1 halt after reset", 32'(halt_req), 0);
    rd_chk(0, 32'h0, "R1 status after reset");
    rd_chk(1, 32'h0, "R1 enable after reset");

    wr(1, 32'h0001_80C0);
    rd_chk(1, 32'h0001_80C0, "R9 enable readback");

    pulse(V_RXD, 0); idle(1);
    chk("R5 irq on enabled rx done", 32'(irq), 1);
    rd_chk(0, 32'h0001_0040, "R2 R4 rx done bit and normal summary");

    pulse(V_RXN, 0);
    wr(0, 32'h40); idle(1);
    chk("R6 irq held by rx no-buffer", 32'(irq), 1);
    rd_chk(0, 32'h0000_8080, "R4 abnormal summary only");

    wr(0, 32'h80); idle(1);
    chk("R7 irq low when all cleared", 32'(irq), 0);
    idle(3);
    chk("R7 irq stays low without event", 32'(irq), 0);

    pulse(V_TXD | V_RXD, 0); idle(1);
    chk("R7 single assertion for joint events", 32'(irq), 1);
    rd_chk(0, 32'h0001_0041, "R2 two bits set");
    wr(0, 32'h40); idle(1);
    chk("R5 disabled pending bit gives no irq", 32'(irq), 0);
    rd_chk(0, 32'h0000_0001, "R5 bit 0 pending, summary low");

    @(negedge clk);
    e_rxd = 1; reg_valid = 1; reg_write = 1; reg_addr = 0; reg_wdata = 32'h40;
    @(negedge clk);
    e_rxd = 0; reg_valid = 0; reg_write = 0;
    idle(1);
    rd_chk(0, 32'h0001_0041, "R3 set wins over clear");
    wr(0, 32'hFFFF_FFFF); idle(1);
    rd_chk(0, 32'h0, "R3 clear all");

    pulse(V_RXD, 0); idle(1);
    wr(0, 32'h0001_8000); idle(1);
    rd_chk(0, 32'h0001_0040, "R4 summary bits not writable");
    wr(0, 32'h0); idle(1);
    rd_chk(0, 32'h0001_0040, "R3 zero write leaves bits");
    wr(0, 32'h40); idle(1);

    pulse(V_BE, 3'd5);
    chk("R8 halt raised", 32'(halt_req), 1);
    rd_chk(0, 32'h0280_2000, "R8 fatal bit and type 5");
    pulse(V_BE, 3'd2);
    rd_chk(0, 32'h0280_2000, "R8 first type kept");
    wr(0, 32'h2000);
    chk("R8 halt released", 32'(halt_req), 0);
    rd_chk(0, 32'h0, "R8 type wiped");

    wr(1, 32'h0001_A0C0);
    pulse(V_BE, 3'd1); idle(1);
    chk("R8 enabled fatal raises irq", 32'(irq), 1);
    wr(0, 32'h2000); idle(1);
    chk("R7 irq drops after fatal clear", 32'(irq), 0);

    rd_chk(2, 32'h0, "R9 unmapped address");
    rd_chk(9, 32'h0, "R9 unmapped address high");
    wr(1, 32'hFFFF_FFFF);
    rd_chk(1, 32'h0001_E1C7, "R9 writable enable bits");

    // random phase, checked by the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      e_txd = ($urandom % 16) == 0;
      e_txs = ($urandom % 32) == 0;
      e_txn = ($urandom % 16) == 0;
      e_rxd = ($urandom % 12) == 0;
      e_rxn = ($urandom % 24) == 0;
      e_rxs = ($urandom % 32) == 0;
      e_rxe = ($urandom % 16) == 0;
      e_be  = ($urandom % 64) == 0;
      e_bt  = 3'($urandom);
      reg_valid = ($urandom % 3) == 0;
      reg_write = ($urandom % 2) == 0;
      reg_addr  = ($urandom % 4 == 0) ? 4'($urandom) : 4'($urandom % 2);
      reg_wdata = (($urandom % 4) == 0) ? 32'hFFFF_FFFF : $urandom;
    end
    @(negedge clk);
    {e_be, e_rxe, e_rxs, e_rxn, e_rxd, e_txn, e_txs, e_txd} = '0;
    reg_valid = 0;
    idle(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule